// File: doc/BRIEF.md
# Double-Buffered Serial Flash Page Writer

This block is a host-side SPI master that moves a byte stream into a serial page-organised flash device. The stream arrives on a valid/ready handshake. A start pulse supplies the first page number. The block packs bytes into pages of 264 and uses the two device SRAM buffers in turn. While the device programs a page from one buffer, the block is already filling the other buffer.

Every page goes through the same steps. A buffer-load frame carries the page data. A status poll then repeats until the device reports ready. Last comes a program-with-erase frame for that buffer, and the page number moves up by one. No fixed delays are used: a status poll paces every array command. A flush input ends the stream. If the buffer holds a partial page, that page is programmed as it is. The block then pulses done once a final poll shows the device idle.

Top module: `flash_pingpong_writer`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, in_ready is 0, done is 0 and busy is 0.
- R2: SPI mode 0. sck idles low whenever cs_n is high. mosi changes only while sck is low. Bits go out MSB first.
- R3: A buffer-load frame sends opcode 84h for buffer A or 87h for buffer B, then 24 zero address bits, then the accepted stream bytes in arrival order starting at buffer byte 0.
- R4: A program frame sends 83h for buffer A or 86h for buffer B, for the buffer just filled. The 24-bit address is {3'b000, page[11:0], 9'b0}.
- R5: A page ends after 264 bytes. The first page of a run uses buffer A at the start page. Each later page uses the other buffer and page+1, wrapping modulo 4096.
- R6: A program frame is sent only after a status frame has returned bit 7 = 1. The status frame is opcode 57h followed by one byte read back. The status frame repeats while bit 7 is 0.
- R7: Filling the next buffer starts right after a program frame, without waiting for the device to become ready.
- R8: cs_n stays high for at least CS_GAP clock cycles between frames. Each sck half period lasts CLK_DIV clock cycles.
- R9: When flush is asserted with a partly filled page, that page is programmed. Its unfilled bytes keep what the buffer held before.
- R10: When flush is asserted with no bytes in the current page, no program frame is sent.
- R11: done is a single-cycle pulse. It comes after the last program frame, once a status poll has shown ready. busy is 1 from start until done.
- R12: in_ready is 1 only in the data phase of a buffer-load frame, while sck is low and flush is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begins a run; latches start_page |
| start_page | input | 12 | First page number of the run |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted this cycle when valid |
| flush | input | 1 | End of stream; hold until done |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| cs_n | output | 1 | SPI chip select, active low |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to the device |
| miso | input | 1 | SPI data from the device |

## Verification
A stream byte is taken on the clock edge where in_valid and in_ready are both high. The bench drives a byte at a falling edge and waits until in_ready is seen high at a falling edge. It then lets one rising edge pass, so each byte is counted once. The device model follows sck and cs_n one clock behind the design. It drives the status bit one clock after the falling sck edge, which is still a full clock before the next rising edge at the divider setting used. done is checked at the falling edge where it is first high, and again one cycle later. Page contents and the program log are compared only after done, when every frame has closed.

// File: rtl/flash_pingpong_writer.sv
module flash_pingpong_writer #(
  parameter int CLK_DIV    = 5,
  parameter int CS_GAP     = 25,
  parameter int PAGE_BYTES = 264,
  parameter int PAGE_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              flush,
  output logic              busy,
  output logic              done,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int AW    = $clog2(PAGE_BYTES);
  localparam int RSV_W = 24 - PAGE_W - AW;
  localparam int CW    = $clog2(PAGE_BYTES + 1);
  localparam int DW    = $clog2(CLK_DIV + 1);
  localparam int GW    = $clog2(CS_GAP + 1);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_BYTE, S_NEXT} st_t;
  typedef enum logic [1:0] {K_WR, K_POLL, K_PROG} kind_t;

  st_t   st;
  kind_t kind;
  logic [7:0]        sh, rx, opc, hdr;
  logic [DW-1:0]     ph;
  logic [2:0]        bitn, idx;
  logic [CW-1:0]     cnt;
  logic [GW-1:0]     gap;
  logic [PAGE_W-1:0] page;
  logic              bsel, pend, last;
  logic [23:0]       addr24;
  logic              hdr_more, page_full;

  always_comb begin
    case (kind)
      K_WR:    opc = bsel ? 8'h87 : 8'h84;
      K_POLL:  opc = 8'h57;
      default: opc = bsel ? 8'h86 : 8'h83;
    endcase
    case (idx)
      3'd1:    hdr = addr24[23:16];
      3'd2:    hdr = addr24[15:8];
      default: hdr = addr24[7:0];
    endcase
  end

  assign addr24    = (kind == K_PROG) ? {{RSV_W{1'b0}}, page, {AW{1'b0}}} : 24'h0;
  assign hdr_more  = (kind == K_POLL) ? (idx == 3'd1) : (idx < 3'd4);
  assign page_full = (cnt == CW'(PAGE_BYTES));
  assign in_ready  = (st == S_NEXT) && (kind == K_WR) && !hdr_more && !page_full && !flush;
  assign busy      = (st != S_IDLE);
  assign mosi      = !cs_n && sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_WR; sh <= '0; rx <= '0; ph <= '0; bitn <= '0;
      idx <= '0; cnt <= '0; gap <= '0; page <= '0; bsel <= 1'b0; pend <= 1'b0;
      last <= 1'b0; cs_n <= 1'b1; sck <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          page <= start_page; bsel <= 1'b0; cnt <= '0; pend <= 1'b0;
          last <= 1'b0; kind <= K_WR; gap <= '0; st <= S_GAP;
        end
        S_GAP: if (gap == GW'(CS_GAP - 1)) begin
          cs_n <= 1'b0; sh <= opc; idx <= 3'd1; ph <= '0; bitn <= '0; st <= S_BYTE;
        end else gap <= gap + 1'b1;
        S_BYTE: if (ph == DW'(CLK_DIV - 1)) begin
          ph <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) st <= S_NEXT;
            else begin
              bitn <= bitn + 1'b1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else ph <= ph + 1'b1;
        default: begin
          if (hdr_more) begin
            sh <= hdr; idx <= idx + 1'b1; ph <= '0; bitn <= '0; st <= S_BYTE;
          end else if (kind == K_WR) begin
            if (in_ready && in_valid) begin
              sh <= in_data; cnt <= cnt + 1'b1; ph <= '0; bitn <= '0; st <= S_BYTE;
            end else if (page_full || flush) begin
              pend <= (cnt != '0); last <= flush; kind <= K_POLL;
              cs_n <= 1'b1; gap <= '0; st <= S_GAP;
            end
          end else if (kind == K_POLL) begin
            cs_n <= 1'b1; gap <= '0;
            if (!rx[7]) st <= S_GAP;
            else if (pend) begin kind <= K_PROG; st <= S_GAP; end
            else begin done <= 1'b1; st <= S_IDLE; end
          end else begin
            page <= page + 1'b1; bsel <= !bsel; pend <= 1'b0; cnt <= '0;
            kind <= last ? K_POLL : K_WR; cs_n <= 1'b1; gap <= '0; st <= S_GAP;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_pingpong_writer_chk.sv
module flash_pingpong_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic in_ready,
  input logic flush,
  input logic done,
  input logic busy
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck); // R2
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (sck && $past(sck)) |-> $stable(mosi)); // R2
  AST_CS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n); // R8
  AST_SCK_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $rose(sck) |=> sck); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cs_n && !busy)); // R11
  AST_READY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) in_ready |-> (!cs_n && !sck && !flush)); // R12
endmodule

bind flash_pingpong_writer flash_pingpong_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
  .in_ready(in_ready), .flush(flush), .done(done), .busy(busy)
);

// File: tb/flash_pingpong_writer_bench.sv
module flash_pingpong_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam int GAPC = 6;
  localparam int PB = 264;
  localparam int BUSY_CYC = 10000;
  localparam int NV = 4;
  localparam logic [27:0] VEC [NV] = '{
    {12'd5, 16'd264}, {12'd10, 16'd600}, {12'd4095, 16'd274}, {12'd7, 16'd0}};

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, flush = 0, miso = 0;
  logic [11:0] start_page = '0;
  logic [7:0] in_data = '0;
  logic in_ready, busy, done, cs_n, sck, mosi;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_pingpong_writer #(.CLK_DIV(DIV), .CS_GAP(GAPC)) u_flash_pingpong_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .flush(flush),
    .busy(busy), .done(done), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso));

  // device model
  logic [7:0] dbuf [2][PB];
  logic [7:0] mem [8][PB];
  logic [11:0] prog_page [16];
  logic prog_b [16];
  int n_prog = 0, arr_err = 0, ovl = 0, gap_err = 0, rsv_err = 0, dev_busy = 0;
  int nb = 0, hi_cnt = 1000, ptr = 0;
  logic [7:0] rs_sh = 0, rs_cmd = 0, stat = 0;
  logic [23:0] rs_addr = 0;
  logic cs_q = 1, sck_q = 0;

  always @(posedge clk) begin
    if (dev_busy > 0) dev_busy = dev_busy - 1;
    if (cs_n) hi_cnt = hi_cnt + 1;
    if (cs_q && !cs_n) begin
      if (hi_cnt < GAPC) gap_err = gap_err + 1;
      hi_cnt = 0; nb = 0; rs_cmd = 0; rs_addr = 0;
    end
    if (!cs_n && sck && !sck_q) begin
      rs_sh = {rs_sh[6:0], mosi};
      nb = nb + 1;
      if (nb % 8 == 0) begin
        if (nb == 8) begin
          rs_cmd = rs_sh;
          if ((rs_cmd == 8'h84 || rs_cmd == 8'h87) && dev_busy > 0) ovl = ovl + 1;
          if (rs_cmd == 8'h57) stat = {dev_busy == 0, 1'b0, 3'b100, 3'b000};
        end else if (nb <= 32) begin
          rs_addr = {rs_addr[15:0], rs_sh};
          if (nb == 32 && (rs_cmd == 8'h84 || rs_cmd == 8'h87)) begin
            if (rs_addr != 0) rsv_err = rsv_err + 1;
            ptr = int'(rs_addr[8:0]) % PB;
          end
        end else if (rs_cmd == 8'h84 || rs_cmd == 8'h87) begin
          dbuf[rs_cmd == 8'h87][ptr] = rs_sh;
          ptr = (ptr + 1) % PB;
        end
      end
    end
    if (!cs_n && !sck && sck_q && rs_cmd == 8'h57 && nb >= 8) begin
      miso <= stat[7];
      stat = {stat[6:0], stat[7]};
    end
    if (cs_n && !cs_q) begin
      miso <= 1'b0;
      if ((rs_cmd == 8'h83 || rs_cmd == 8'h86) && nb == 32) begin
        if (dev_busy > 0) arr_err = arr_err + 1;
        if (rs_addr[23:21] != 0 || rs_addr[8:0] != 0) rsv_err = rsv_err + 1;
        for (int i = 0; i < PB; i++) mem[rs_addr[11:9]][i] = dbuf[rs_cmd == 8'h86][i];
        if (n_prog < 16) begin
          prog_page[n_prog] = rs_addr[20:9];
          prog_b[n_prog] = (rs_cmd == 8'h86);
        end
        n_prog = n_prog + 1;
        dev_busy = BUSY_CYC;
      end
    end
    cs_q = cs_n;
    sck_q = sck;
  end

  function automatic logic [7:0] pat(int r, int i);
    return 8'((i * 7 + r * 29 + 3) ^ (i >> 8));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    in_valid = 1;
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sck == 0 && in_ready == 0 && done == 0 && busy == 0, "R1 reset state",
        {cs_n, sck, in_ready, done, busy}, 5'b10000);
    in_valid = 0;
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(in_ready == 0 && busy == 0, "R12 idle no ready", in_ready, 0);

    for (int r = 0; r < NV; r++) begin
      int n, np, base, arr0, gap0, rsv0, ovl0, viol, t, sawdone, errs, pend_leftover;
      logic [11:0] sp;
      sp = VEC[r][27:16]; n = int'(VEC[r][15:0]);
      np = (n + PB - 1) / PB;
      base = n_prog; arr0 = arr_err; gap0 = gap_err; rsv0 = rsv_err; ovl0 = ovl;
      @(negedge clk); start_page = sp; start = 1;
      @(negedge clk); start = 0;
      chk(busy == 1, "R11 busy after start", busy, 1);
      for (int i = 0; i < n; i++) begin
        in_data = pat(r, i); in_valid = 1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
      end
      in_valid = 0; flush = 1;
      viol = 0; sawdone = 0; t = 0;
      while (!sawdone && t < 120000) begin
        @(negedge clk); t++;
        if (in_ready) viol++;
        if (done) sawdone = 1;
      end
      chk(sawdone == 1 && busy == 0, "R11 done seen with busy low", sawdone, 1);
      chk(dev_busy == 0, "R11 done only after device ready", dev_busy, 0);
      @(negedge clk);
      chk(done == 0, "R11 done single pulse", done, 0);
      flush = 0;
      chk(viol == 0, "R12 no ready while flushing", viol, 0);
      chk(n_prog - base == np, (np == 0) ? "R10 no program on empty flush" : "R5 program count",
          n_prog - base, np);
      chk(arr_err == arr0, "R6 array command only when ready", arr_err - arr0, 0);
      chk(gap_err == gap0, "R8 chip-select high gap", gap_err - gap0, 0);
      chk(rsv_err == rsv0, "R4 address fields", rsv_err - rsv0, 0);
      if (np > 1) chk(ovl > ovl0, "R7 fill overlaps programming", ovl - ovl0, 1);
      for (int k = 0; k < np && base + k < 16; k++) begin
        chk(prog_page[base + k] == 12'(int'(sp) + k), "R5 page sequence",
            prog_page[base + k], int'(12'(int'(sp) + k)));
        chk(prog_b[base + k] == k[0], "R4 buffer alternation", prog_b[base + k], k % 2);
        errs = 0; pend_leftover = 0;
        for (int i = 0; i < PB; i++) begin
          if (k * PB + i < n) begin
            if (mem[prog_page[base + k][2:0]][i] != pat(r, k * PB + i)) errs++;
          end else if (k >= 2) begin
            pend_leftover = 1;
            if (mem[prog_page[base + k][2:0]][i] != pat(r, (k - 2) * PB + i)) errs++;
          end
        end
        chk(errs == 0, pend_leftover ? "R9 partial page keeps old bytes" : "R3 page data", errs, 0);
      end
      repeat (5) @(negedge clk);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule